// File: doc/BRIEF.md
# Write-in-progress status responder

This block decides what a byte-wide nonvolatile memory puts on its data bus when the host reads it while a write is still in flight. From the moment the write controller latches a byte until the internal programming cycle finishes, reads do not return array contents. They return a status word instead. Its top bit is the complement of the top bit of the last byte latched. The next bit flips from one read to the next and starts at zero. The third bit tells whether the page-load window is still open or internal programming has begun. The remaining low bits are left undriven.

The write controller supplies a level that is high while the page-load window is open, a level that is high while internal programming runs, and a one-cycle strobe with the data byte each time it latches a byte. The read side supplies a read-enable level (one read is one high pulse of that level) and the normal array read data. When no write is pending, reads pass the array data straight through with every bit driven. Outside read cycles nothing is driven. The programming timer itself lives in the write controller.

The data width is a parameter (at least 4). The three status bits always occupy the three most significant positions. A second parameter selects whether the inverted poll bit is also presented during the page-load window or only during programming.

Top module: `wip_status_resp`

## Requirements
- R1: After reset no write is pending, the toggle state is 0 and, with the read enable low, `bus_oe_o` is all zeros.
- R2: Whenever `rd_en_i` is low, `bus_oe_o` is all zeros and `bus_o` is all zeros.
- R3: With no byte latched since the last completed cycle, a read drives every bit and returns `array_data_i`, even if `prog_busy_i` is high.
- R4: A write is pending from the cycle after a `byte_latch_i` strobe while `load_window_i` or `prog_busy_i` stays high. A read in that state drives only the three most significant bits (`bus_oe_o` = 8'hE0 at width 8), and the undriven bits of `bus_o` read 0.
- R5: During a pending write with `prog_busy_i` high, bit DATA_W-1 of a read is the complement of bit DATA_W-1 of the most recently latched byte. With POLL_IN_WINDOW=1 (default) the same holds while only `load_window_i` is high. With POLL_IN_WINDOW=0, the true bit is returned in that case.
- R6: Bit DATA_W-2 of a status read is the toggle state. The first read of a cycle returns 0, and the state inverts when each status read ends (falling edge of `rd_en_i`).
- R7: Bit DATA_W-3 of a status read is 0 while `prog_busy_i` is low (page-load window) and 1 while `prog_busy_i` is high.
- R8: Once `load_window_i` and `prog_busy_i` are both low, reads again return `array_data_i` with all bits driven, and reads no longer change the toggle state.
- R9: The first byte latched while no write is pending clears the toggle state, so the first status read of every new cycle returns 0 in bit DATA_W-2.
- R10: When several bytes are latched in one cycle, the poll bit follows the most recent one, and the later latches do not clear the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_window_i | input | 1 | Page-load window open (from write controller) |
| prog_busy_i | input | 1 | Internal programming cycle running |
| byte_latch_i | input | 1 | One-cycle strobe: a byte was latched |
| latch_data_i | input | DATA_W | Byte latched with the strobe |
| rd_en_i | input | 1 | Read cycle active (output enable) |
| array_data_i | input | DATA_W | Normal array read data |
| bus_o | output | DATA_W | Value for the data bus |
| bus_oe_o | output | DATA_W | Per-bit drive enable for the data bus |

## Verification
On every cycle the assertions check the following:
- the bus is released outside reads;
- only the top three bits are driven while a write is pending;
- the poll bit is the complement of the latched bit during programming;
- the toggle inverts exactly when a status read ends and holds otherwise;
- it is cleared by the first latch of a cycle.

Only the bench scenarios show that the toggle sequence seen by the host starts at 0 in every cycle, whatever number of reads the previous cycle made. The same holds for the hand-over back to array data at the end of a cycle, and for the sweep of the poll bit over every latched byte value.

// File: rtl/wip_pkg.sv
package wip_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_PROG = 2'd2
   } wip_phase_e;

   localparam int unsigned STATUS_BITS = 3;
endpackage

// File: rtl/wip_track.sv
module wip_track
   import wip_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_window_i,
   input  logic              prog_busy_i,
   input  logic              byte_latch_i,
   input  logic [DATA_W-1:0] latch_data_i,
   input  logic              rd_en_i,
   output wip_phase_e        phase_o,
   output logic              armed_o,
   output logic              toggle_o,
   output logic              last_msb_o,
   output logic              rd_q_o
);
   logic armed_q, toggle_q, last_msb_q, rd_q;
   logic active, rd_end;

   assign active = armed_q & (load_window_i | prog_busy_i);
   assign rd_end = rd_q & ~rd_en_i;

   always_comb begin
      if (!active)          phase_o = PH_IDLE;
      else if (prog_busy_i) phase_o = PH_PROG;
      else                  phase_o = PH_LOAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         toggle_q   <= 1'b0;
         last_msb_q <= 1'b0;
         rd_q       <= 1'b0;
      end else begin
         rd_q <= rd_en_i;
         if (byte_latch_i) begin
            armed_q    <= 1'b1;
            last_msb_q <= latch_data_i[DATA_W-1];
            if (!active) toggle_q <= 1'b0;
         end else begin
            if (!(load_window_i | prog_busy_i)) armed_q <= 1'b0;
            if (active && rd_end) toggle_q <= ~toggle_q;
         end
      end
   end

   assign armed_o    = armed_q;
   assign toggle_o   = toggle_q;
   assign last_msb_o = last_msb_q;
   assign rd_q_o     = rd_q;
endmodule

// File: rtl/wip_compose.sv
module wip_compose
   import wip_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter bit          POLL_IN_WINDOW = 1'b1
) (
   input  wip_phase_e        phase_i,
   input  logic              rd_en_i,
   input  logic              toggle_i,
   input  logic              last_msb_i,
   input  logic [DATA_W-1:0] array_data_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] bus_oe_o
);
   localparam int unsigned LOW_W = DATA_W - STATUS_BITS;
   localparam logic [DATA_W-1:0] STATUS_OE = {{STATUS_BITS{1'b1}}, {LOW_W{1'b0}}};

   logic poll_bit;

   generate
      if (POLL_IN_WINDOW) begin : g_poll_both
         assign poll_bit = ~last_msb_i;
      end else begin : g_poll_prog
         assign poll_bit = (phase_i == PH_PROG) ? ~last_msb_i : last_msb_i;
      end
   endgenerate

   always_comb begin
      bus_o    = '0;
      bus_oe_o = '0;
      if (rd_en_i) begin
         if (phase_i == PH_IDLE) begin
            bus_o    = array_data_i;
            bus_oe_o = '1;
         end else begin
            bus_o    = {poll_bit, toggle_i, (phase_i == PH_PROG), {LOW_W{1'b0}}};
            bus_oe_o = STATUS_OE;
         end
      end
   end
endmodule

// File: rtl/wip_status_resp.sv
module wip_status_resp
   import wip_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter bit          POLL_IN_WINDOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_window_i,
   input  logic              prog_busy_i,
   input  logic              byte_latch_i,
   input  logic [DATA_W-1:0] latch_data_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] array_data_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] bus_oe_o
);
   generate
      if (DATA_W < STATUS_BITS + 1) begin : g_bad_width
         $error("wip_status_resp: DATA_W must be at least 4");
      end
   endgenerate

   wip_phase_e phase_w;
   logic       armed_w, toggle_w, last_msb_w, rd_q_w;

   wip_track #(.DATA_W(DATA_W)) track_i (
      .clk(clk), .rst_n(rst_n),
      .load_window_i(load_window_i), .prog_busy_i(prog_busy_i),
      .byte_latch_i(byte_latch_i), .latch_data_i(latch_data_i),
      .rd_en_i(rd_en_i),
      .phase_o(phase_w), .armed_o(armed_w), .toggle_o(toggle_w),
      .last_msb_o(last_msb_w), .rd_q_o(rd_q_w)
   );

   wip_compose #(.DATA_W(DATA_W), .POLL_IN_WINDOW(POLL_IN_WINDOW)) compose_i (
      .phase_i(phase_w), .rd_en_i(rd_en_i), .toggle_i(toggle_w),
      .last_msb_i(last_msb_w), .array_data_i(array_data_i),
      .bus_o(bus_o), .bus_oe_o(bus_oe_o)
   );
endmodule

// File: rtl/wip_status_resp_chk.sv
module wip_status_resp_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_window_i,
   input logic              prog_busy_i,
   input logic              byte_latch_i,
   input logic              rd_en_i,
   input logic [DATA_W-1:0] bus_o,
   input logic [DATA_W-1:0] bus_oe_o,
   input logic              armed_w,
   input logic              toggle_w,
   input logic              last_msb_w,
   input logic              rd_q_w
);
   localparam logic [DATA_W-1:0] STAT_OE = {3'b111, {(DATA_W-3){1'b0}}};
   logic pend;
   assign pend = armed_w & (load_window_i | prog_busy_i);

   assert_bus_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> (bus_oe_o == '0));

   assert_status_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && pend) |-> (bus_oe_o == STAT_OE));

   assert_idle_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !pend) |-> (bus_oe_o == '1));

   assert_poll_inverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && pend && prog_busy_i) |-> (bus_o[DATA_W-1] == ~last_msb_w));

   assert_timer_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && pend) |-> (bus_o[DATA_W-3] == prog_busy_i));

   assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && rd_q_w && !rd_en_i && !byte_latch_i) |=> (toggle_w != $past(toggle_w)));

   assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !byte_latch_i) |=> $stable(toggle_w));

   assert_toggle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_latch_i && !pend) |=> !toggle_w);
endmodule

bind wip_status_resp wip_status_resp_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .load_window_i(load_window_i),
   .prog_busy_i(prog_busy_i), .byte_latch_i(byte_latch_i), .rd_en_i(rd_en_i),
   .bus_o(bus_o), .bus_oe_o(bus_oe_o), .armed_w(armed_w), .toggle_w(toggle_w),
   .last_msb_w(last_msb_w), .rd_q_w(rd_q_w)
);

// File: tb/wip_status_resp_tb.sv
module wip_status_resp_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_window_i = 1'b0, prog_busy_i = 1'b0, byte_latch_i = 1'b0, rd_en_i = 1'b0;
   logic [7:0] latch_data_i = '0, array_data_i = '0;
   logic [7:0] bus_o, bus_oe_o;
   int         n_chk = 0, n_fail = 0;
   bit         tog;

   always #5 clk = ~clk;

   wip_status_resp dut_i (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic latch(input logic [7:0] d);
      latch_data_i = d; byte_latch_i = 1'b1; step();
      byte_latch_i = 1'b0; step();
   endtask

   // one read: value and enables sampled away from the edge, then read ends
   task automatic rd(input string req, input logic [7:0] ev, input logic [7:0] eoe);
      rd_en_i = 1'b1;
      @(negedge clk);
      check({req, " data"}, bus_o, ev);
      check({req, " oe"}, bus_oe_o, eoe);
      step(); rd_en_i = 1'b0; step();
      check({req, " released R2"}, bus_oe_o, 8'h00);
   endtask

   initial begin
      step(); step();
      @(negedge clk);
      check("R1 oe at reset", bus_oe_o, 8'h00);
      check("R2 bus at reset", bus_o, 8'h00);
      rst_n = 1'b1; step();
      // R3: busy but nothing latched
      prog_busy_i = 1'b1; array_data_i = 8'hC3;
      rd("R3 no latch", 8'hC3, 8'hFF);
      prog_busy_i = 1'b0; step();
      // sweep every latched value through one full cycle
      for (int d = 0; d < 256; d++) begin
         int nr = (d % 4) + 1;
         array_data_i = 8'(d) ^ 8'h5A;
         load_window_i = 1'b1;
         latch(8'(d));
         tog = 1'b0;
         // R9/R6/R7/R5 in page-load window: first read toggle 0, timer bit 0
         rd("R9 R5 R7 window", {~d[7], tog, 1'b0, 5'b0}, 8'hE0);
         tog = ~tog;
         if (d % 8 == 3) begin
            // R10: a second byte in the same page, opposite msb, toggle kept
            latch(8'(d) ^ 8'h80);
            rd("R10 second latch", {d[7], tog, 1'b0, 5'b0}, 8'hE0);
            tog = ~tog;
            latch(8'(d));
         end
         load_window_i = 1'b0; prog_busy_i = 1'b1; step();
         for (int k = 0; k < nr; k++) begin
            rd("R6 R5 R7 R4 prog", {~d[7], tog, 1'b1, 5'b0}, 8'hE0);
            tog = ~tog;
         end
         prog_busy_i = 1'b0; step();
         // R8: complete, array data, no toggle effect
         rd("R8 done", 8'(d) ^ 8'h5A, 8'hFF);
         rd("R8 done again", 8'(d) ^ 8'h5A, 8'hFF);
      end
      // R2 check while status pending but no read
      load_window_i = 1'b1; latch(8'h80);
      @(negedge clk);
      check("R2 pending no read", bus_oe_o, 8'h00);
      rd("R4 R5 msb set", 8'h40 & 8'h00, 8'hE0);
      load_window_i = 1'b0; step();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule